// File: doc/BRIEF.md
# Sector Range Erase Sequencer

This block erases an inclusive range of flash sectors through a simple memory-bus master port. It takes a start pulse with a first and a last sector index, a family select and a protect vector. It first validates the range and counts the protected sectors inside it. It then walks the range in ascending order and skips every protected sector. For each remaining sector it issues the family's erase command sequence and waits a fixed minimum number of ticks. It then polls the sector until every data lane reports ready.

Sector start addresses come from an external lookup. The block presents `sect_idx` and reads back the matching `sect_addr` in the same cycle. `bank_base` gives the first address of the bank, and the unlock offsets are added to it. Time is counted in cycles of the `tick` enable strobe. The minimum wait, the erase timeout and the heartbeat period are all parameters in ticks.

If a sector does not finish before the timeout, the block abandons the whole range. It issues a suspend command if the family needs one, then returns the bank to read mode and reports a failure.

Top module: `sect_erase_seq`

## Requirements
- R1: A start whose `first_idx` is negative, or greater than `last_idx` (both signed), ends with `fail`=1 and `prot_count`=0, and no bus cycle is issued.
- R2: From the cycle after an accepted start, `prot_count` equals the number of set `protect` bits with index in [first, last], as sampled at start.
- R3: Sectors are visited in ascending index order. A protected sector receives no bus cycle of any kind.
- R4: With `family`=1, each sector is erased by three writes to its start address: 0x50, then 0x20, then 0xD0.
- R5: With `family`=0, each sector is erased by six writes. The first five go to `bank_base` plus an offset: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA. The sixth is 0x30 to the sector start address. Every command byte sits in bits [7:0] of each LANE_W-bit lane, and the other bits are zero.
- R6: No status read of a sector starts before DELAY_TICKS ticks have passed since the last erase write of that sector completed.
- R7: A sector is finished only when bit 7 of every lane of a status read is 1. A read with only some lanes ready leads to another poll.
- R8: After each finished sector, the read-mode command is written to `bank_base`: 0xFF for family 1 and 0xF0 for family 0.
- R9: If TIMEOUT_TICKS ticks pass without the sector finishing, family 1 first writes 0xB0 to the sector address. Both families then write the read-mode command to `bank_base`, raise `fail`, and process no further sector.
- R10: `heartbeat` is a one-cycle pulse after every HB_TICKS ticks spent waiting on a sector. The count restarts at each accepted start, and there is no pulse while idle.
- R11: `busy` is high from the cycle after an accepted start until `done`, which is a one-cycle pulse. A start while busy is ignored.
- R12: `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` stable until the cycle in which `bus_ack` is seen. Read data is taken from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable strobe |
| start | input | 1 | Start pulse, sampled when idle |
| family | input | 1 | Command family: 0 = six-write, 1 = three-write |
| first_idx | input | IDX_W | First sector of the range, signed |
| last_idx | input | IDX_W | Last sector of the range, signed |
| protect | input | NUM_SECT | One protect bit per sector |
| sect_idx | output | SEL_W | Sector index for the address lookup |
| sect_addr | input | ADDR_W | Start address of sector `sect_idx` |
| bank_base | input | ADDR_W | First address of the bank |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | LANES*LANE_W | Write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| bus_rdata | input | LANES*LANE_W | Read data, valid with `bus_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one-cycle pulse |
| fail | output | 1 | Result of the last operation |
| prot_count | output | CNT_W | Protected sectors in the range |
| heartbeat | output | 1 | Progress pulse while waiting |

## Verification
The assertions assume that `bus_ack` only answers a pending `bus_req`, lasts one cycle, and comes no earlier than the cycle after the request rose. They also assume the only write data that can look like a final erase command is 0x30 or 0xD0 in the low byte of lane 0. The bench's bus model meets this. It acknowledges every request after exactly one wait cycle and returns status words chosen per run: ready, ready in only the upper lane, or never ready. Ranges, families and protect vectors are drawn at random within the sector count. Directed runs add the rejected ranges, fully protected ranges and a start issued during a run.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ERASE,
    ST_WAIT,
    ST_POLL,
    ST_SUSP,
    ST_RDMODE,
    ST_DONE
  } seq_state_t;

  localparam logic FAM_SIX   = 1'b0;
  localparam logic FAM_THREE = 1'b1;

  localparam logic [7:0] CMD_UNLK_A   = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B   = 8'h55;
  localparam logic [7:0] CMD_ERASE_MD = 8'h80;
  localparam logic [7:0] CMD_SECT_ER  = 8'h30;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ER_SETUP = 8'h20;
  localparam logic [7:0] CMD_ER_CONF  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RD_SIX   = 8'hF0;
  localparam logic [7:0] CMD_RD_THREE = 8'hFF;

  localparam logic [11:0] OFS_UNLK1 = 12'h555;
  localparam logic [11:0] OFS_UNLK2 = 12'h2AA;

endpackage

// File: rtl/range_prot_count.sv
module range_prot_count #(
  parameter int NUM_SECT = 16,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 5
) (
  input  logic signed [IDX_W-1:0] lo,
  input  logic signed [IDX_W-1:0] hi,
  input  logic [NUM_SECT-1:0]     prot,
  output logic [CNT_W-1:0]        count
);

  logic [NUM_SECT-1:0] hit;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    localparam logic signed [IDX_W-1:0] S_IDX = IDX_W'(s);
    assign hit[s] = prot[s] && (S_IDX >= lo) && (S_IDX <= hi);
  end

  always_comb begin
    count = '0;
    for (int s = 0; s < NUM_SECT; s++) begin
      count = count + CNT_W'(hit[s]);
    end
  end

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import sect_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANES  = 2,
  parameter int LANE_W = 16,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              family,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] sect,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              final_step
);

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: 8] = b;
    return r;
  endfunction

  logic [ADDR_W-1:0] a_u1, a_u2;
  assign a_u1 = base + ADDR_W'(OFS_UNLK1);
  assign a_u2 = base + ADDR_W'(OFS_UNLK2);

  always_comb begin
    addr       = sect;
    data       = '0;
    final_step = 1'b0;
    if (family == FAM_THREE) begin
      case (step)
        3'd0:    data = rep(CMD_CLR_STAT);
        3'd1:    data = rep(CMD_ER_SETUP);
        default: begin data = rep(CMD_ER_CONF); final_step = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0:    begin addr = a_u1; data = rep(CMD_UNLK_A);   end
        3'd1:    begin addr = a_u2; data = rep(CMD_UNLK_B);   end
        3'd2:    begin addr = a_u1; data = rep(CMD_ERASE_MD); end
        3'd3:    begin addr = a_u1; data = rep(CMD_UNLK_A);   end
        3'd4:    begin addr = a_u2; data = rep(CMD_UNLK_B);   end
        default: begin data = rep(CMD_SECT_ER); final_step = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/erase_tick_timers.sv
module erase_tick_timers #(
  parameter int DELAY_TICKS   = 1000,
  parameter int TIMEOUT_TICKS = 100000,
  parameter int HB_TICKS      = 1000000,
  localparam int DW = $clog2(DELAY_TICKS + 1),
  localparam int TW = $clog2(TIMEOUT_TICKS + 1),
  localparam int HW = $clog2(HB_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic hb_clear,
  input  logic waiting,
  output logic min_done,
  output logic expired,
  output logic hb_pulse
);

  localparam logic [DW-1:0] DLY_MAX = DW'(DELAY_TICKS);
  localparam logic [TW-1:0] TMO_MAX = TW'(TIMEOUT_TICKS);
  localparam logic [HW-1:0] HB_LAST = HW'(HB_TICKS - 1);

  logic [DW-1:0] dly_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [HW-1:0] hb_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dly_cnt <= '0;
      tmo_cnt <= '0;
    end else if (tick) begin
      if (dly_cnt != DLY_MAX) dly_cnt <= dly_cnt + 1'b1;
      if (tmo_cnt != TMO_MAX) tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hb_clear) begin
      hb_cnt   <= '0;
      hb_pulse <= 1'b0;
    end else begin
      hb_pulse <= 1'b0;
      if (waiting && tick) begin
        if (hb_cnt == HB_LAST) begin
          hb_cnt   <= '0;
          hb_pulse <= 1'b1;
        end else begin
          hb_cnt <= hb_cnt + 1'b1;
        end
      end
    end
  end

  assign min_done = (dly_cnt == DLY_MAX);
  assign expired  = (tmo_cnt == TMO_MAX);

endmodule

// File: rtl/bus_port_master.sv
module bus_port_master #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cmd_done  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req  <= 1'b0;
          cmd_done <= 1'b1;
          rsp_data <= bus_rdata;
        end
      end else if (cmd_valid && !cmd_done) begin
        bus_req   <= 1'b1;
        bus_we    <= cmd_we;
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_we ? cmd_data : '0;
      end
    end
  end

endmodule

// File: rtl/sect_erase_seq.sv
module sect_erase_seq
  import sect_erase_pkg::*;
#(
  parameter int NUM_SECT      = 16,
  parameter int ADDR_W        = 24,
  parameter int LANES         = 2,
  parameter int LANE_W        = 16,
  parameter int DELAY_TICKS   = 1000,
  parameter int TIMEOUT_TICKS = 100000,
  parameter int HB_TICKS      = 1000000,
  localparam int SEL_W  = $clog2(NUM_SECT),
  localparam int IDX_W  = SEL_W + 1,
  localparam int CNT_W  = $clog2(NUM_SECT + 1),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    start,
  input  logic                    family,
  input  logic signed [IDX_W-1:0] first_idx,
  input  logic signed [IDX_W-1:0] last_idx,
  input  logic [NUM_SECT-1:0]     protect,
  output logic [SEL_W-1:0]        sect_idx,
  input  logic [ADDR_W-1:0]       sect_addr,
  input  logic [ADDR_W-1:0]       bank_base,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_ack,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    busy,
  output logic                    done,
  output logic                    fail,
  output logic [CNT_W-1:0]        prot_count,
  output logic                    heartbeat
);

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: 8] = b;
    return r;
  endfunction

  seq_state_t          state;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    last_q;
  logic                fam_q;
  logic [NUM_SECT-1:0] prot_q;
  logic [2:0]          step;
  logic                abort_q;

  logic                range_bad;
  logic [CNT_W-1:0]    cnt_now;

  logic                cmd_valid, cmd_we, cmd_done;
  logic [ADDR_W-1:0]   cmd_addr;
  logic [DATA_W-1:0]   cmd_data, rsp_data;

  logic [ADDR_W-1:0]   seq_addr;
  logic [DATA_W-1:0]   seq_data;
  logic                seq_final;

  logic                min_done, expired;
  logic                tmr_restart, hb_clear, waiting;
  logic [LANES-1:0]    lane_rdy;
  logic                all_rdy;

  assign range_bad = first_idx[IDX_W-1] || (first_idx > last_idx);

  range_prot_count #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .lo(first_idx), .hi(last_idx), .prot(protect), .count(cnt_now)
  );

  erase_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_seq (
    .family(fam_q), .step(step), .base(bank_base), .sect(sect_addr),
    .addr(seq_addr), .data(seq_data), .final_step(seq_final)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_rdy[l] = rsp_data[l*LANE_W + 7];
  end
  assign all_rdy = &lane_rdy;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_we    = 1'b1;
    cmd_addr  = bank_base;
    cmd_data  = '0;
    case (state)
      ST_ERASE: begin
        cmd_valid = 1'b1;
        cmd_addr  = seq_addr;
        cmd_data  = seq_data;
      end
      ST_POLL: begin
        cmd_valid = 1'b1;
        cmd_we    = 1'b0;
        cmd_addr  = sect_addr;
      end
      ST_SUSP: begin
        cmd_valid = 1'b1;
        cmd_addr  = sect_addr;
        cmd_data  = rep(CMD_SUSPEND);
      end
      ST_RDMODE: begin
        cmd_valid = 1'b1;
        cmd_addr  = bank_base;
        cmd_data  = rep(fam_q == FAM_THREE ? CMD_RD_THREE : CMD_RD_SIX);
      end
      default: ;
    endcase
  end

  bus_port_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  assign tmr_restart = (state == ST_ERASE) && cmd_done && seq_final;
  assign hb_clear    = (state == ST_IDLE) && start;
  assign waiting     = (state == ST_WAIT) || (state == ST_POLL);

  erase_tick_timers #(
    .DELAY_TICKS(DELAY_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS), .HB_TICKS(HB_TICKS)
  ) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .restart(tmr_restart), .hb_clear(hb_clear),
    .waiting(waiting), .min_done(min_done), .expired(expired), .hb_pulse(heartbeat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      last_q     <= '0;
      fam_q      <= 1'b0;
      prot_q     <= '0;
      step       <= '0;
      abort_q    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      prot_count <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            fam_q   <= family;
            prot_q  <= protect;
            abort_q <= 1'b0;
            idx     <= first_idx;
            last_q  <= last_idx;
            if (range_bad) begin
              fail       <= 1'b1;
              prot_count <= '0;
              state      <= ST_DONE;
            end else begin
              fail       <= 1'b0;
              prot_count <= cnt_now;
              state      <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (idx > last_q) begin
            state <= ST_DONE;
          end else if (prot_q[idx[SEL_W-1:0]]) begin
            idx <= idx + 1'b1;
          end else begin
            step  <= '0;
            state <= ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (cmd_done) begin
            if (seq_final) state <= ST_WAIT;
            else           step  <= step + 1'b1;
          end
        end
        ST_WAIT: begin
          if (min_done) state <= ST_POLL;
        end
        ST_POLL: begin
          if (cmd_done) begin
            if (all_rdy) begin
              state <= ST_RDMODE;
            end else if (expired) begin
              abort_q <= 1'b1;
              state   <= (fam_q == FAM_THREE) ? ST_SUSP : ST_RDMODE;
            end
          end
        end
        ST_SUSP: begin
          if (cmd_done) state <= ST_RDMODE;
        end
        ST_RDMODE: begin
          if (cmd_done) begin
            if (abort_q) begin
              fail  <= 1'b1;
              state <= ST_DONE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        ST_DONE: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sect_idx = idx[SEL_W-1:0];

endmodule

// File: rtl/sect_erase_seq_chk.sv
module sect_erase_seq_chk #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int DELAY_TICKS = 1000,
  localparam int DW = $clog2(DELAY_TICKS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              busy,
  input logic              done,
  input logic              heartbeat
);

  localparam logic [DW-1:0] DLY_MAX = DW'(DELAY_TICKS);

  logic [DW-1:0] since_erase;
  logic          final_wr;

  assign final_wr = bus_req && bus_ack && bus_we && (bus_wdata[15:8] == 8'h00) &&
                    ((bus_wdata[7:0] == 8'h30) || (bus_wdata[7:0] == 8'hD0));

  always_ff @(posedge clk) begin
    if (rst || final_wr)                         since_erase <= '0;
    else if (tick && since_erase != DLY_MAX)     since_erase <= since_erase + 1'b1;
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_no_bus_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  p_hb_busy_r10: assert property (@(posedge clk) disable iff (rst)
    heartbeat |-> busy);

  p_min_wait_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) && !bus_we |-> since_erase == DLY_MAX);

endmodule

bind sect_erase_seq sect_erase_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DELAY_TICKS(DELAY_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .busy(busy), .done(done), .heartbeat(heartbeat)
);

// File: tb/tb_sect_erase_seq.sv
module tb_sect_erase_seq;

  localparam int NUM_SECT = 8;
  localparam int ADDR_W   = 24;
  localparam int LANES    = 2;
  localparam int LANE_W   = 16;
  localparam int DELAY    = 5;
  localparam int TMO      = 30;
  localparam int HB       = 7;
  localparam int SEL_W    = 3;
  localparam int IDX_W    = 4;
  localparam int CNT_W    = 4;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] BASE = 24'h010000;

  logic clk = 0, rst = 1, tick = 0, start = 0, family = 0;
  logic signed [IDX_W-1:0] first_idx = 0, last_idx = 0;
  logic [NUM_SECT-1:0] protect = 0;
  logic [SEL_W-1:0] sect_idx;
  logic [ADDR_W-1:0] sect_addr;
  logic bus_req, bus_we, bus_ack = 0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata = 0;
  logic busy, done, fail, heartbeat;
  logic [CNT_W-1:0] prot_count;

  assign sect_addr = BASE + (ADDR_W'(sect_idx) << 12);

  sect_erase_seq #(
    .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W),
    .DELAY_TICKS(DELAY), .TIMEOUT_TICKS(TMO), .HB_TICKS(HB)
  ) dut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .family(family),
    .first_idx(first_idx), .last_idx(last_idx), .protect(protect),
    .sect_idx(sect_idx), .sect_addr(sect_addr), .bank_base(BASE),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .fail(fail), .prot_count(prot_count), .heartbeat(heartbeat)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cycles = 0;
  int tick_total = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  // tick strobe every fourth cycle, driven on the falling edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tick) tick_total <= tick_total + 1;
  end

  // flash bus model with one wait cycle, write log, scripted status
  int log_n = 0;
  logic [ADDR_W-1:0] log_a [256];
  logic [DATA_W-1:0] log_d [256];
  int cfg_busy = 0;
  bit cfg_never = 0;
  int polls_left = 0;
  int erase_tick = 0;
  bit first_read = 0;
  bit seen = 0;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic s_we;
  int hb_seen = 0;
  int hold_bad = 0;

  always @(negedge clk) begin
    if (heartbeat) hb_seen++;
    if (bus_ack) begin
      bus_ack = 0;
    end else if (seen) begin
      if (!bus_req || bus_addr != s_addr || bus_wdata != s_data || bus_we != s_we) hold_bad++;
      seen = 0;
      bus_ack = 1;
      if (bus_we) begin
        if (log_n < 256) begin
          log_a[log_n] = bus_addr;
          log_d[log_n] = bus_wdata;
        end
        log_n++;
        if (bus_wdata == rep(8'h30) || bus_wdata == rep(8'hD0)) begin
          polls_left = cfg_busy;
          erase_tick = tick_total;
          first_read = 1;
        end
      end else begin
        if (first_read) begin
          chk(tick_total - erase_tick >= DELAY, "R6 ticks before first poll",
              tick_total - erase_tick, DELAY);
          first_read = 0;
        end
        if (cfg_never || polls_left > 0) begin
          bus_rdata = 32'h0080_0000;
          if (polls_left > 0) polls_left--;
        end else begin
          bus_rdata = 32'h0080_0080;
        end
      end
    end else if (bus_req) begin
      seen = 1;
      s_addr = bus_addr;
      s_data = bus_wdata;
      s_we = bus_we;
    end
  end

  // expected write list, built from the requirements
  int exp_n;
  logic [ADDR_W-1:0] exp_a [256];
  logic [DATA_W-1:0] exp_d [256];
  bit exp_fail;
  int exp_cnt;

  function automatic void push(input logic [ADDR_W-1:0] a, input logic [7:0] b);
    exp_a[exp_n] = a;
    exp_d[exp_n] = rep(b);
    exp_n++;
  endfunction

  function automatic void build(input int f, input int l, input bit fam,
                                input logic [NUM_SECT-1:0] pv, input bit never);
    logic [ADDR_W-1:0] sa;
    exp_n = 0;
    exp_cnt = 0;
    exp_fail = 0;
    if (f < 0 || f > l) begin
      exp_fail = 1;
      return;
    end
    for (int s = f; s <= l; s++) if (pv[s]) exp_cnt++;
    for (int s = f; s <= l; s++) begin
      if (pv[s]) continue;
      sa = BASE + (ADDR_W'(s) << 12);
      if (fam) begin
        push(sa, 8'h50); push(sa, 8'h20); push(sa, 8'hD0);
      end else begin
        push(BASE + 24'h555, 8'hAA); push(BASE + 24'h2AA, 8'h55);
        push(BASE + 24'h555, 8'h80); push(BASE + 24'h555, 8'hAA);
        push(BASE + 24'h2AA, 8'h55); push(sa, 8'h30);
      end
      if (never) begin
        if (fam) push(sa, 8'hB0);
        push(BASE, 8'hFF);
        if (!fam) exp_d[exp_n-1] = rep(8'hF0);
        exp_fail = 1;
        break;
      end
      push(BASE, fam ? 8'hFF : 8'hF0);
    end
  endfunction

  task automatic run(input int f, input int l, input bit fam, input logic [NUM_SECT-1:0] pv,
                     input int bpolls, input bit never, input bit restart_mid, input string tag);
    int waitc;
    int bad;
    build(f, l, fam, pv, never);
    cfg_busy = bpolls;
    cfg_never = never;
    log_n = 0;
    hb_seen = 0;
    @(negedge clk);
    first_idx = IDX_W'(f);
    last_idx = IDX_W'(l);
    family = fam;
    protect = pv;
    start = 1;
    @(negedge clk);
    start = 0;
    // R11: busy right after start; R2: count in place one cycle after
    chk(busy == 1'b1, {tag, " R11 busy after start"}, busy, 1);
    if (!exp_fail || never)
      chk(prot_count == CNT_W'(exp_cnt), {tag, " R2 prot_count early"}, prot_count, exp_cnt);
    if (restart_mid) begin
      repeat (20) @(negedge clk);
      first_idx = 0; last_idx = 7; family = ~fam; protect = 0;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (!done && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    chk(done == 1'b1, {tag, " R11 done seen"}, done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R11 done one cycle, busy low"}, {done, busy}, 0);
    chk(fail == exp_fail, {tag, " R1 R9 fail result"}, fail, exp_fail);
    chk(prot_count == CNT_W'(exp_cnt), {tag, " R2 prot_count"}, prot_count, exp_cnt);
    chk(log_n == exp_n, {tag, " R3 R4 R5 R8 write count"}, log_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_a[i] != exp_a[i] || log_d[i] != exp_d[i])) bad = i;
    if (bad >= 0)
      chk(0, {tag, " R3 R4 R5 R8 R9 write list"}, {log_a[bad], log_d[bad]}, {exp_a[bad], exp_d[bad]});
    else
      chk(1, {tag, " write list"}, 0, 0);
    chk(hold_bad == 0, {tag, " R12 request held until ack"}, hold_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && bus_req == 0 && heartbeat == 0 && prot_count == 0,
        "reset state R11", {busy, done, fail, bus_req, heartbeat}, 0);

    run(-1, 3, 1, 8'h00, 0, 0, 0, "R1 negative first");
    run(5, 2, 0, 8'h24, 0, 0, 0, "R1 first above last");
    run(1, 3, 1, 8'h00, 2, 0, 0, "R4 R7 family three partial lanes");
    run(0, 7, 0, 8'b1010_0110, 1, 0, 0, "R5 R3 family six with protect");
    run(4, 4, 1, 8'h10, 0, 0, 0, "R3 single protected");
    run(0, 7, 1, 8'hFF, 0, 0, 0, "R2 all protected");
    run(2, 5, 1, 8'h00, 0, 1, 0, "R9 timeout family three");
    chk(hb_seen >= TMO / HB && hb_seen <= (TMO + 2) / HB, "R10 heartbeat count",
        hb_seen, TMO / HB);
    run(1, 6, 0, 8'b0000_0010, 0, 1, 0, "R9 timeout family six");
    run(3, 6, 0, 8'b0010_0000, 0, 0, 1, "R11 start ignored while busy");
    repeat (30) @(negedge clk);
    chk(hb_seen == 0 || !busy, "R10 no heartbeat idle", heartbeat, 0);
    chk(heartbeat == 0, "R10 heartbeat low when idle", heartbeat, 0);

    for (int k = 0; k < 6; k++) begin
      int f, l;
      f = $urandom_range(0, NUM_SECT - 1);
      l = $urandom_range(f, NUM_SECT - 1);
      run(f, l, 1'($urandom_range(0, 1)), 8'($urandom), $urandom_range(0, 3), 0, 0, "random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule